// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

The controller connects a synchronous request port to an external asynchronous static RAM with a 19-bit address and an 8-bit data bus. A requester presents one read or one write with a valid/ready handshake. The controller then runs the memory's active-low chip, output and write strobes through a fixed series of clock phases. Each phase lasts a parameterised number of clocks, so that the memory's minimum pulse widths, setup times and hold times are met at the clock rate in use.

Read data comes back on a single-cycle response pulse. The shared data bus is split into an output value, an output enable and an input value. The controller drives the bus only while the memory's output enable is high. Write data stays on the bus across the write-enable rising edge that ends the write. At the default of one clock per phase and a 100 MHz clock, a read takes two clocks of strobe and a write takes three: setup, write pulse, and hold.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and whenever the controller is idle, mem_ce_no, mem_oe_no and mem_we_no are all 1, mem_dq_oe_o is 0 and req_ready_o is 1.
- R2: req_ready_o is 1 only while idle. It falls on the clock edge that accepts a request (req_valid_i and req_ready_o both 1) and stays 0 until the operation ends. While it is 0, a held req_valid_i starts nothing.
- R3: A read holds mem_ce_no=0, mem_oe_no=0 and mem_we_no=1 with an unchanged mem_addr_o for RD_ACC_CYC+1 clock cycles. The response data equals the memory byte at the requested address.
- R4: For a read, rsp_valid_o rises on the (RD_ACC_CYC+2)-th rising edge after the cycle in which the request was seen accepted, and it stays high for exactly one cycle. req_ready_o returns on that same edge.
- R5: A write holds mem_ce_no=0 and mem_oe_no=1 throughout. mem_we_no is 1 for WR_SETUP_CYC cycles, then 0 for WR_PULSE_CYC cycles, then 1 for WR_HOLD_CYC cycles. mem_oe_no and mem_we_no are never both 0.
- R6: During a write, mem_dq_oe_o is 1 from the first setup cycle to the last hold cycle, and mem_dq_o is unchanged over that span. mem_dq_oe_o is still 1 in the cycle after mem_we_no rises. mem_addr_o does not change while mem_ce_no stays 0.
- R7: mem_dq_oe_o is 1 only while mem_oe_no is 1, so the controller and the memory never drive the bus together.
- R8: A write produces no rsp_valid_o pulse. req_ready_o returns WR_SETUP_CYC+WR_PULSE_CYC+WR_HOLD_CYC+1 rising edges after the cycle in which the request was seen accepted.
- R9: Operation type, address and write data are captured on the accepting edge. Changes on req_write_i, req_addr_i or req_wdata_i after that edge have no effect on the operation under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Single-cycle read data strobe |
| rsp_rdata_o | output | DATA_W | Read data |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_dq_o | output | DATA_W | Data driven onto the bus |
| mem_dq_oe_o | output | 1 | Controller bus driver enable |
| mem_dq_i | input | DATA_W | Data bus as seen at the pins |

## Verification
The bench counts rising edges from the cycle in which it sees a request accepted. A read response is due RD_ACC_CYC+2 edges later, together with the return of ready. After a write, ready is due WR_SETUP_CYC+WR_PULSE_CYC+WR_HOLD_CYC+1 edges later, with no response pulse at any point. On every falling edge, ready, the response strobe and the response data are compared with the values due in that cycle, so an output that comes one cycle early or late fails. A behavioural memory on the pins counts how many cycles each strobe stays low. It checks those counts against the phase lengths when the strobe rises, and it flags any cycle in which both sides drive the bus.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_STRB,
    ST_RD_SMPL,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drive;
  } strobe_t;

  function automatic strobe_t strobe_of(seq_state_e s);
    strobe_t r;
    r = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
    unique case (s)
      ST_RD_STRB,
      ST_RD_SMPL:  begin r.ce_n = 1'b0; r.oe_n = 1'b0; end
      ST_WR_SETUP,
      ST_WR_HOLD:  begin r.ce_n = 1'b0; r.drive = 1'b1; end
      ST_WR_PULSE: begin r.ce_n = 1'b0; r.we_n = 1'b0; r.drive = 1'b1; end
      default:     r = r;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_ACC_CYC   = 1,
  parameter int WR_SETUP_CYC = 1,
  parameter int WR_PULSE_CYC = 1,
  parameter int WR_HOLD_CYC  = 1,
  parameter int CNT_W        = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_write_i,
  input  logic             phase_done_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             capture_o,
  output logic             ready_o,
  output strobe_t          strobe_o
);

  seq_state_e state_q, state_d;
  strobe_t    strobe_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = start_write_i ? ST_WR_SETUP : ST_RD_STRB;
      ST_RD_STRB:  if (phase_done_i) state_d = ST_RD_SMPL;
      ST_RD_SMPL:  state_d = ST_IDLE;
      ST_WR_SETUP: if (phase_done_i) state_d = ST_WR_PULSE;
      ST_WR_PULSE: if (phase_done_i) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  if (phase_done_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // phase length minus one, loaded when a phase is entered
  always_comb begin
    load_o     = (state_d != state_q);
    load_val_o = '0;
    unique case (state_d)
      ST_RD_STRB:  load_val_o = CNT_W'(RD_ACC_CYC - 1);
      ST_WR_SETUP: load_val_o = CNT_W'(WR_SETUP_CYC - 1);
      ST_WR_PULSE: load_val_o = CNT_W'(WR_PULSE_CYC - 1);
      ST_WR_HOLD:  load_val_o = CNT_W'(WR_HOLD_CYC - 1);
      default:     load_val_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      strobe_q <= strobe_of(ST_IDLE);
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_of(state_d);
    end
  end

  assign capture_o = (state_q == ST_RD_SMPL);
  assign ready_o   = (state_q == ST_IDLE);
  assign strobe_o  = strobe_q;

  AST_SMPL_AFTER_STRB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_SMPL) |-> $past(state_q) == ST_RD_STRB) else $error("sample without strobe"); // R3

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic              drive_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rsp_valid_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  // sample on the edge that ends the strobe; address is held until next accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= capture_i;
      if (capture_i) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = drive_i;
  assign rdata_o     = rdata_q;
  assign rsp_valid_o = rsp_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 8,
  parameter int RD_ACC_CYC   = 1,
  parameter int WR_SETUP_CYC = 1,
  parameter int WR_PULSE_CYC = 1,
  parameter int WR_HOLD_CYC  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int MAX_AB  = (RD_ACC_CYC > WR_SETUP_CYC) ? RD_ACC_CYC : WR_SETUP_CYC;
  localparam int MAX_CD  = (WR_PULSE_CYC > WR_HOLD_CYC) ? WR_PULSE_CYC : WR_HOLD_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             accept, load, phase_done, capture;
  logic [CNT_W-1:0] load_val;
  strobe_t          strobe;

  assign accept = req_valid_i && req_ready_o;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (phase_done)
  );

  sram_seq_fsm #(
    .RD_ACC_CYC   (RD_ACC_CYC),
    .WR_SETUP_CYC (WR_SETUP_CYC),
    .WR_PULSE_CYC (WR_PULSE_CYC),
    .WR_HOLD_CYC  (WR_HOLD_CYC),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (accept),
    .start_write_i (req_write_i),
    .phase_done_i  (phase_done),
    .load_o        (load),
    .load_val_o    (load_val),
    .capture_o     (capture),
    .ready_o       (req_ready_o),
    .strobe_o      (strobe)
  );

  sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .capture_i   (capture),
    .drive_i     (strobe.drive),
    .mem_dq_i    (mem_dq_i),
    .mem_addr_o  (mem_addr_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o),
    .rdata_o     (rsp_rdata_o),
    .rsp_valid_o (rsp_valid_o)
  );

  assign mem_ce_no = strobe.ce_n;
  assign mem_oe_no = strobe.oe_n;
  assign mem_we_no = strobe.we_n;

  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_no && mem_oe_no && mem_we_no && !mem_dq_oe_o)) else $error("idle pins"); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o) else $error("ready after accept"); // R2
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o) else $error("rsp longer than one cycle"); // R4
  AST_WE_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && mem_oe_no)) else $error("we without ce or with oe"); // R5
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> mem_dq_oe_o) else $error("data dropped at we rise"); // R6
  AST_WDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o)) else $error("wdata moved"); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o)) else $error("addr moved"); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no) else $error("bus contention"); // R7

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int RD = 1;
  localparam int WS = 1;
  localparam int WP = 1;
  localparam int WH = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready_o, rsp_valid_o, mem_ce_no, mem_oe_no, mem_we_no, mem_dq_oe_o;
  logic [DW-1:0] rsp_rdata_o, mem_dq_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_rd_q = 8'hEE;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int busy_until = 0;
  int rsp_due = -1;
  logic [DW-1:0] exp_rdata = '0;
  logic [DW-1:0] ref_mem [int];
  logic [DW-1:0] pin_mem [int];
  int wr_run = 0, rd_run = 0;
  logic [DW-1:0] wr_dat = '0;
  logic [AW-1:0] wr_adr = '0, rd_adr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_async_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .RD_ACC_CYC(RD),
    .WR_SETUP_CYC(WS), .WR_PULSE_CYC(WP), .WR_HOLD_CYC(WH)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .mem_addr_o(mem_addr_o), .mem_ce_no(mem_ce_no), .mem_oe_no(mem_oe_no),
    .mem_we_no(mem_we_no), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
    .mem_dq_i(mem_rd_q)
  );

  function automatic logic [DW-1:0] init_val(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // pin-level memory model and reference model, evaluated away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit exp_ready = (cyc >= busy_until);
      automatic bit mem_drive = !mem_ce_no && !mem_oe_no && mem_we_no;
      check(req_ready_o == exp_ready, "R2", "ready", req_ready_o, exp_ready);
      check(rsp_valid_o == (cyc == rsp_due), "R4,R8", "rsp_valid", rsp_valid_o, cyc == rsp_due);
      if (rsp_valid_o && cyc == rsp_due)
        check(rsp_rdata_o == exp_rdata, "R3,R9", "rdata", rsp_rdata_o, exp_rdata);
      if (exp_ready)
        check(mem_ce_no && mem_oe_no && mem_we_no && !mem_dq_oe_o, "R1", "idle pins",
              {mem_ce_no, mem_oe_no, mem_we_no, mem_dq_oe_o}, 4'b1110);
      if (mem_dq_oe_o)
        check(!mem_drive, "R7", "contention", mem_drive, 0);
      if (!mem_oe_no || !mem_we_no)
        check(mem_oe_no || mem_we_no, "R5", "oe and we low", {mem_oe_no, mem_we_no}, 2'b01);

      // write pulse tracking
      if (!mem_ce_no && !mem_we_no) begin
        check(mem_dq_oe_o, "R6", "drive in pulse", mem_dq_oe_o, 1);
        if (wr_run > 0) begin
          check(mem_dq_o == wr_dat, "R6", "wdata stable", mem_dq_o, wr_dat);
          check(mem_addr_o == wr_adr, "R6", "waddr stable", mem_addr_o, wr_adr);
        end
        wr_dat = mem_dq_o; wr_adr = mem_addr_o;
        wr_run++;
      end else if (wr_run > 0) begin
        check(wr_run == WP, "R5", "we pulse cycles", wr_run, WP);
        check(mem_dq_oe_o && mem_dq_o == wr_dat, "R6", "data held past we rise", mem_dq_oe_o, 1);
        pin_mem[int'(wr_adr)] = wr_dat;
        wr_run = 0;
      end

      // read strobe tracking
      if (mem_drive) begin
        if (rd_run > 0 && mem_addr_o != rd_adr) begin
          check(0, "R3", "read addr moved", mem_addr_o, rd_adr);
          rd_run = 0;
        end
        rd_adr = mem_addr_o;
        rd_run++;
      end else if (rd_run > 0) begin
        check(rd_run == RD + 1, "R3", "read strobe cycles", rd_run, RD + 1);
        rd_run = 0;
      end

      // reference model: acceptance seen in this cycle
      if (req_valid && exp_ready) begin
        if (req_write) begin
          ref_mem[int'(req_addr)] = req_wdata;
          busy_until = cyc + 1 + WS + WP + WH;
        end else begin
          exp_rdata  = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : init_val(req_addr);
          rsp_due    = cyc + RD + 2;
          busy_until = rsp_due;
        end
      end

      mem_rd_q = mem_drive ? (pin_mem.exists(int'(mem_addr_o)) ? pin_mem[int'(mem_addr_o)]
                                                               : init_val(mem_addr_o))
                           : 8'hEE;
    end
  end

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    automatic bit taken = 1'b0;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!taken) begin
      @(negedge clk);
      taken = req_ready_o;
      @(posedge clk); #2;
    end
    // scramble inputs after acceptance
    req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(mem_ce_no && mem_oe_no && mem_we_no && !mem_dq_oe_o && req_ready_o && !rsp_valid_o,
          "R1", "reset pins", {mem_ce_no, mem_oe_no, mem_we_no, mem_dq_oe_o}, 4'b1110);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (2) @(posedge clk); #2;

    do_op(1'b1, 19'h00000, 8'h3C);
    do_op(1'b0, 19'h00000, 8'h00);
    repeat (3) @(posedge clk); #2;
    do_op(1'b1, 19'h7FFFF, 8'hFF);
    do_op(1'b0, 19'h7FFFF, 8'h00);
    do_op(1'b0, 19'h12345, 8'h00);
    do_op(1'b1, 19'h12345, 8'h00);
    do_op(1'b0, 19'h12345, 8'h77);
    for (int i = 0; i < 16; i++)
      do_op(1'b1, AW'(i * 4099), DW'(i * 17 + 1));
    for (int i = 15; i >= 0; i--) begin
      do_op(1'b0, AW'(i * 4099), 8'h00);
      if (i % 4 == 0) begin repeat (2) @(posedge clk); #2; end
    end
    do_op(1'b1, 19'h00000, 8'hA5);
    do_op(1'b0, 19'h00000, 8'h00);
    do_op(1'b0, 19'h40000, 8'h00);
    repeat (8) @(posedge clk);
    @(negedge clk);
    check(req_ready_o && !rsp_valid_o, "R8", "final idle", req_ready_o, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule